// File: doc/BRIEF.md
# Per-Thread Load/Store Issue Queue

This block is the entry stage of a multithreaded load/store pipeline. Each cycle it can accept one load or store from operand fetch, tagged with a hardware thread number. Before the request is stored, the block decodes the access size. It then places scalar store data and its byte-enable mask at the right byte lanes of a line-wide vector. For vector accesses it packs the significant part of each 32-bit lane so that those bytes become contiguous. The result goes into the FIFO that belongs to the request's thread.

The head of every thread FIFO is offered to the next stage in parallel, one entry per thread. That stage pops a thread's FIFO by raising that thread's bit in a dequeue mask; while the bit is low, the head stays where it is. Each thread also has a single recycle slot. The next stage loads an instruction into this slot when the instruction misses further down. While the slot is occupied, it is offered for that thread in place of the FIFO head. A separate per-thread strobe clears the slot. Cache lookup, arbitration between threads and memory all sit outside this block.

Top module: `ldst_issue_queue`

## Requirements
- R1: After reset, no thread has a valid head, a valid recycle slot or a full FIFO, and `inReady` is high for every thread id below NT.
- R2: A request is written only into the FIFO numbered `inThread`. The write happens when `inValid` or `inFlush` is high, `rollback` is low and that FIFO is not full. A flush is written with its flush bit set even when `inValid` is low. With both `inValid` and `inFlush` low, nothing is written.
- R3: While `rollback` is high, `inReady` is low and no FIFO is written.
- R4: A FIFO holding DEPTH entries raises its `fifoFull` bit. While it is full, `inReady` is low for that thread, and a further request to it is dropped even if the same cycle pops it.
- R5: Each FIFO returns entries in write order. An entry leaves only in a cycle where the thread's `dequeueMask` bit is high, and the head stays unchanged otherwise. A dequeue bit on an empty FIFO has no effect.
- R6: `inSize` encodes 0 = byte, 1 = halfword, 2 = word, and 3 is treated as word. For a scalar access, the byte offset is the low log2(4·LANES) address bits rounded down to the access size. The low 1, 2 or 4 bytes of `inData` are placed starting at that offset, and the mask has exactly those bytes set. All other data bits are zero.
- R7: A vector byte access takes the low byte of each 32-bit lane i of `inData` and writes it to byte i of the stored data. The mask covers bytes 0 to LANES-1, and all other bytes are zero.
- R8: A vector halfword access writes the low half of lane i to halfword i, with a mask covering the low 2·LANES bytes. A vector word access stores `inData` unchanged with every mask bit set.
- R9: `missValid` loads `missEntry` into the recycle slot of `missThread` at the next edge. While that slot is valid, the thread's offered entry is the recycled one. A load and a clear of the same slot in one cycle leave it valid.
- R10: A `recycleConsume` bit clears only that thread's recycle slot and leaves its FIFO untouched. A FIFO dequeue leaves the recycle slot untouched.
- R11: The entry layout, from bit 0 upward, is: mask (4·LANES bits), data (32·LANES), address (ADDR_W), tag (TAG_W), size (2), vector flag, flush flag, load flag. With the defaults these occupy bits 0-63, 64-575, 576-607, 608-615, 616-617, 618, 619 and 620, for 621 bits in total.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| inValid | input | 1 | Incoming instruction is valid |
| inFlush | input | 1 | Incoming request is a flush |
| inThread | input | TID_W | Thread id of the incoming request |
| inIsLoad | input | 1 | Request is a load |
| inIsVector | input | 1 | Request is a vector access |
| inSize | input | 2 | Access size code |
| inTag | input | TAG_W | Instruction tag carried with the entry |
| inAddr | input | ADDR_W | Effective address |
| inData | input | 32·LANES | Store operand; scalar data in bits 31:0 |
| rollback | input | 1 | Rollback in progress; blocks enqueue |
| inReady | output | 1 | The request's target FIFO can accept it now |
| dequeueMask | input | NT | Per-thread FIFO pop |
| recycleConsume | input | NT | Per-thread recycle slot clear |
| missValid | input | 1 | Load a missed instruction into a recycle slot |
| missThread | input | TID_W | Thread of the missed instruction |
| missEntry | input | ENTRY_W | Missed instruction in entry layout |
| headValid | output | NT | FIFO of the thread is non-empty |
| recycleValid | output | NT | Recycle slot of the thread is occupied |
| fifoFull | output | NT | FIFO of the thread is full |
| offerEntry | output | NT·ENTRY_W | Offered entry per thread: recycle slot if valid, else FIFO head |

## Verification
Some properties are checked on every cycle. A full FIFO stays full unless it is popped, and ready is low for a full target or during rollback. An idle thread's FIFO stays empty. The head does not move without a dequeue. A miss load always leaves the slot valid, and a consume without a load always empties it. Other behaviour shows only in the bench's scenarios, which compare stored values with values computed from the requirements. These scenarios cover the byte lanes and masks chosen for each size and offset, the packing of vector lanes, write order across several entries, the flush bit, and the routing of each request to its thread.

// File: rtl/lsq_pkg.sv
package lsq_pkg;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_RSVD = 2'd3
  } accSize_e;

  // per-thread strobes from control to datapath
  typedef struct packed {
    logic push;
    logic pop;
    logic recLoad;
    logic recClear;
  } lsqStrobe_t;

endpackage

// File: rtl/lsq_align.sv
module lsq_align
  import lsq_pkg::*;
#(
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  localparam int DATA_W = LANES * 32,
  localparam int MASK_W = LANES * 4,
  localparam int OFF_W  = $clog2(MASK_W)
) (
  input  logic              isVector,
  input  logic [1:0]        sizeCode,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] rawData,
  output logic [DATA_W-1:0] alignedData,
  output logic [MASK_W-1:0] alignedMask
);

  accSize_e          sizeDec;
  logic [OFF_W-1:0]  offRaw;
  logic [OFF_W-1:0]  offUsed;
  logic [DATA_W-1:0] scalarData;
  logic [MASK_W-1:0] scalarMask;
  logic [DATA_W-1:0] packByte;
  logic [DATA_W-1:0] packHalf;
  logic [MASK_W-1:0] maskByteVec;
  logic [MASK_W-1:0] maskHalfVec;

  assign sizeDec = accSize_e'(sizeCode);
  assign offRaw  = addr[OFF_W-1:0];

  // scalar placement at the size-aligned byte offset
  always_comb begin
    offUsed    = offRaw;
    scalarData = '0;
    scalarMask = '0;
    unique case (sizeDec)
      SZ_BYTE: begin
        offUsed    = offRaw;
        scalarData = DATA_W'(rawData[7:0]) << {offUsed, 3'b000};
        scalarMask = MASK_W'(1) << offUsed;
      end
      SZ_HALF: begin
        offUsed    = {offRaw[OFF_W-1:1], 1'b0};
        scalarData = DATA_W'(rawData[15:0]) << {offUsed, 3'b000};
        scalarMask = MASK_W'(2'b11) << offUsed;
      end
      default: begin
        offUsed    = {offRaw[OFF_W-1:2], 2'b00};
        scalarData = DATA_W'(rawData[31:0]) << {offUsed, 3'b000};
        scalarMask = MASK_W'(4'hF) << offUsed;
      end
    endcase
  end

  // vector compaction: significant part of each lane made contiguous
  always_comb begin
    packByte    = '0;
    packHalf    = '0;
    maskByteVec = '0;
    maskHalfVec = '0;
    for (int i = 0; i < LANES; i++) begin
      packByte[8*i +: 8]        = rawData[32*i +: 8];
      packHalf[16*i +: 16]      = rawData[32*i +: 16];
      maskByteVec[i]            = 1'b1;
      maskHalfVec[2*i +: 2]     = 2'b11;
    end
  end

  always_comb begin
    if (!isVector) begin
      alignedData = scalarData;
      alignedMask = scalarMask;
    end else begin
      unique case (sizeDec)
        SZ_BYTE: begin
          alignedData = packByte;
          alignedMask = maskByteVec;
        end
        SZ_HALF: begin
          alignedData = packHalf;
          alignedMask = maskHalfVec;
        end
        default: begin
          alignedData = rawData;
          alignedMask = '1;
        end
      endcase
    end
  end

endmodule

// File: rtl/lsq_ctrl.sv
module lsq_ctrl
  import lsq_pkg::*;
#(
  parameter int NT = 4,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input  logic                   inValid,
  input  logic                   inFlush,
  input  logic [TID_W-1:0]       inThread,
  input  logic                   rollback,
  input  logic [NT-1:0]          dequeueMask,
  input  logic [NT-1:0]          recycleConsume,
  input  logic                   missValid,
  input  logic [TID_W-1:0]       missThread,
  input  logic [NT-1:0]          fifoFull,
  input  logic [NT-1:0]          fifoEmpty,
  output logic                   inReady,
  output lsqStrobe_t [NT-1:0]    strobes
);

  logic targetFull;
  logic accept;

  always_comb begin
    targetFull = 1'b1;  // unknown thread ids are never accepted
    for (int t = 0; t < NT; t++) begin
      if (inThread == TID_W'(t)) targetFull = fifoFull[t];
    end
    inReady = !targetFull && !rollback;
    accept  = (inValid || inFlush) && inReady;
  end

  always_comb begin
    for (int t = 0; t < NT; t++) begin
      strobes[t].push     = accept && (inThread == TID_W'(t));
      strobes[t].pop      = dequeueMask[t] && !fifoEmpty[t];
      strobes[t].recLoad  = missValid && (missThread == TID_W'(t));
      strobes[t].recClear = recycleConsume[t] && !strobes[t].recLoad;
    end
  end

endmodule

// File: rtl/lsq_datapath.sv
module lsq_datapath
  import lsq_pkg::*;
#(
  parameter int NT     = 4,
  parameter int DEPTH  = 4,
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8,
  localparam int DATA_W  = LANES * 32,
  localparam int MASK_W  = LANES * 4,
  localparam int ENTRY_W = MASK_W + DATA_W + ADDR_W + TAG_W + 5,
  localparam int PTR_W   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CNT_W   = $clog2(DEPTH + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  lsqStrobe_t [NT-1:0]     strobes,
  input  logic                    inFlush,
  input  logic                    inIsLoad,
  input  logic                    inIsVector,
  input  logic [1:0]              inSize,
  input  logic [TAG_W-1:0]        inTag,
  input  logic [ADDR_W-1:0]       inAddr,
  input  logic [DATA_W-1:0]       inData,
  input  logic [ENTRY_W-1:0]      missEntry,
  output logic [NT-1:0]           fifoFull,
  output logic [NT-1:0]           fifoEmpty,
  output logic [NT-1:0]           recValid,
  output logic [NT*ENTRY_W-1:0]   offerEntry
);

  logic [DATA_W-1:0]  alignedData;
  logic [MASK_W-1:0]  alignedMask;
  logic [ENTRY_W-1:0] newEntry;

  lsq_align #(.LANES(LANES), .ADDR_W(ADDR_W)) i_align (
    .isVector    (inIsVector),
    .sizeCode    (inSize),
    .addr        (inAddr),
    .rawData     (inData),
    .alignedData (alignedData),
    .alignedMask (alignedMask)
  );

  assign newEntry = {inIsLoad, inFlush, inIsVector, inSize, inTag, inAddr,
                     alignedData, alignedMask};

  for (genvar t = 0; t < NT; t++) begin : g_thread
    logic [ENTRY_W-1:0] slots [DEPTH];
    logic [PTR_W-1:0]   wrPtr;
    logic [PTR_W-1:0]   rdPtr;
    logic [CNT_W-1:0]   count;
    logic               recValidQ;
    logic [ENTRY_W-1:0] recEntryQ;

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        wrPtr <= '0;
        rdPtr <= '0;
        count <= '0;
      end else begin
        if (strobes[t].push)
          wrPtr <= (wrPtr == PTR_W'(DEPTH - 1)) ? '0 : wrPtr + 1'b1;
        if (strobes[t].pop)
          rdPtr <= (rdPtr == PTR_W'(DEPTH - 1)) ? '0 : rdPtr + 1'b1;
        unique case ({strobes[t].push, strobes[t].pop})
          2'b10:   count <= count + 1'b1;
          2'b01:   count <= count - 1'b1;
          default: count <= count;
        endcase
      end
    end

    always_ff @(posedge clk) begin
      if (strobes[t].push) slots[wrPtr] <= newEntry;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        recValidQ <= 1'b0;
        recEntryQ <= '0;
      end else if (strobes[t].recLoad) begin
        recValidQ <= 1'b1;
        recEntryQ <= missEntry;
      end else if (strobes[t].recClear) begin
        recValidQ <= 1'b0;
      end
    end

    assign fifoFull[t]  = (count == CNT_W'(DEPTH));
    assign fifoEmpty[t] = (count == '0);
    assign recValid[t]  = recValidQ;
    assign offerEntry[t*ENTRY_W +: ENTRY_W] = recValidQ ? recEntryQ : slots[rdPtr];
  end

endmodule

// File: rtl/ldst_issue_queue.sv
module ldst_issue_queue
  import lsq_pkg::*;
#(
  parameter int NT     = 4,
  parameter int DEPTH  = 4,
  parameter int LANES  = 16,
  parameter int ADDR_W = 32,
  parameter int TAG_W  = 8,
  localparam int TID_W   = (NT > 1) ? $clog2(NT) : 1,
  localparam int DATA_W  = LANES * 32,
  localparam int MASK_W  = LANES * 4,
  localparam int ENTRY_W = MASK_W + DATA_W + ADDR_W + TAG_W + 5
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   inValid,
  input  logic                   inFlush,
  input  logic [TID_W-1:0]       inThread,
  input  logic                   inIsLoad,
  input  logic                   inIsVector,
  input  logic [1:0]             inSize,
  input  logic [TAG_W-1:0]       inTag,
  input  logic [ADDR_W-1:0]      inAddr,
  input  logic [DATA_W-1:0]      inData,
  input  logic                   rollback,
  output logic                   inReady,
  input  logic [NT-1:0]          dequeueMask,
  input  logic [NT-1:0]          recycleConsume,
  input  logic                   missValid,
  input  logic [TID_W-1:0]       missThread,
  input  logic [ENTRY_W-1:0]     missEntry,
  output logic [NT-1:0]          headValid,
  output logic [NT-1:0]          recycleValid,
  output logic [NT-1:0]          fifoFull,
  output logic [NT*ENTRY_W-1:0]  offerEntry
);

  lsqStrobe_t [NT-1:0] strobes;
  logic [NT-1:0]       fifoEmpty;

  lsq_ctrl #(.NT(NT)) i_ctrl (
    .inValid        (inValid),
    .inFlush        (inFlush),
    .inThread       (inThread),
    .rollback       (rollback),
    .dequeueMask    (dequeueMask),
    .recycleConsume (recycleConsume),
    .missValid      (missValid),
    .missThread     (missThread),
    .fifoFull       (fifoFull),
    .fifoEmpty      (fifoEmpty),
    .inReady        (inReady),
    .strobes        (strobes)
  );

  lsq_datapath #(
    .NT(NT), .DEPTH(DEPTH), .LANES(LANES), .ADDR_W(ADDR_W), .TAG_W(TAG_W)
  ) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .strobes    (strobes),
    .inFlush    (inFlush),
    .inIsLoad   (inIsLoad),
    .inIsVector (inIsVector),
    .inSize     (inSize),
    .inTag      (inTag),
    .inAddr     (inAddr),
    .inData     (inData),
    .missEntry  (missEntry),
    .fifoFull   (fifoFull),
    .fifoEmpty  (fifoEmpty),
    .recValid   (recycleValid),
    .offerEntry (offerEntry)
  );

  assign headValid = ~fifoEmpty;

endmodule

// File: rtl/lsq_checker.sv
module lsq_checker #(
  parameter int NT = 4,
  parameter int ENTRY_W = 621,
  localparam int TID_W = (NT > 1) ? $clog2(NT) : 1
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  inValid,
  input logic                  inFlush,
  input logic [TID_W-1:0]      inThread,
  input logic                  rollback,
  input logic                  inReady,
  input logic [NT-1:0]         dequeueMask,
  input logic [NT-1:0]         recycleConsume,
  input logic                  missValid,
  input logic [TID_W-1:0]      missThread,
  input logic [NT-1:0]         headValid,
  input logic [NT-1:0]         recycleValid,
  input logic [NT-1:0]         fifoFull,
  input logic [NT*ENTRY_W-1:0] offerEntry
);

  // R3
  rollback_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rollback |-> !inReady);

  for (genvar t = 0; t < NT; t++) begin : g_chk
    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      fifoFull[t] && !dequeueMask[t] |=> fifoFull[t]);
    // R4
    full_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (inThread == TID_W'(t)) && fifoFull[t] |-> !inReady);
    // R2
    idle_no_enq_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !headValid[t] && !inValid && !inFlush |=> !headValid[t]);
    // R5
    head_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      headValid[t] && !dequeueMask[t] && !recycleValid[t]
      && !(missValid && missThread == TID_W'(t))
      |=> headValid[t] && $stable(offerEntry[t*ENTRY_W +: ENTRY_W]));
    // R9
    recycle_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
      missValid && missThread == TID_W'(t) |=> recycleValid[t]);
    // R10
    recycle_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      recycleConsume[t] && !(missValid && missThread == TID_W'(t)) |=> !recycleValid[t]);
  end

endmodule

bind ldst_issue_queue lsq_checker #(.NT(NT), .ENTRY_W(ENTRY_W)) i_lsq_checker (.*);

// File: tb/test_ldst_issue_queue.sv
module test_ldst_issue_queue;

  localparam int NT = 4, DEPTH = 4, LANES = 16, ADDR_W = 32, TAG_W = 8;
  localparam int TID_W = 2, DATA_W = LANES * 32, MASK_W = LANES * 4;
  localparam int ENTRY_W = MASK_W + DATA_W + ADDR_W + TAG_W + 5;
  localparam int DATA_LSB = MASK_W, ADDR_LSB = DATA_LSB + DATA_W;
  localparam int TAG_LSB = ADDR_LSB + ADDR_W, SIZE_LSB = TAG_LSB + TAG_W;
  localparam int VEC_BIT = SIZE_LSB + 2, FLUSH_BIT = VEC_BIT + 1, LOAD_BIT = FLUSH_BIT + 1;

  // {size[2], addr[6], data[32], expected offset[6], byte count[3]}
  localparam int NROWS = 8;
  localparam logic [48:0] ROWS [NROWS] = '{
    {2'd0, 6'd0,  32'h1234_56A5, 6'd0,  3'd1},
    {2'd0, 6'd37, 32'hFFFF_FF3C, 6'd37, 3'd1},
    {2'd0, 6'd63, 32'h0000_007E, 6'd63, 3'd1},
    {2'd1, 6'd19, 32'hAAAA_BEEF, 6'd18, 3'd2},
    {2'd1, 6'd62, 32'h5555_1234, 6'd62, 3'd2},
    {2'd2, 6'd43, 32'hDEAD_BEEF, 6'd40, 3'd4},
    {2'd2, 6'd60, 32'hCAFE_F00D, 6'd60, 3'd4},
    {2'd3, 6'd7,  32'h0102_0304, 6'd4,  3'd4}
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic inValid, inFlush, inIsLoad, inIsVector, rollback, inReady, missValid;
  logic [TID_W-1:0] inThread, missThread;
  logic [1:0] inSize;
  logic [TAG_W-1:0] inTag;
  logic [ADDR_W-1:0] inAddr;
  logic [DATA_W-1:0] inData;
  logic [NT-1:0] dequeueMask, recycleConsume, headValid, recycleValid, fifoFull;
  logic [ENTRY_W-1:0] missEntry;
  logic [NT*ENTRY_W-1:0] offerEntry;

  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  ldst_issue_queue #(.NT(NT), .DEPTH(DEPTH), .LANES(LANES), .ADDR_W(ADDR_W), .TAG_W(TAG_W))
  i_ldst_issue_queue (.*);

  task automatic check(input string req, input logic [DATA_W-1:0] act, input logic [DATA_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [ENTRY_W-1:0] offerOf(input int t);
    return offerEntry[t*ENTRY_W +: ENTRY_W];
  endfunction

  task automatic idle();
    inValid = 0; inFlush = 0; inThread = '0; inIsLoad = 0; inIsVector = 0;
    inSize = 2'd2; inTag = '0; inAddr = '0; inData = '0; rollback = 0;
    dequeueMask = '0; recycleConsume = '0; missValid = 0; missThread = '0; missEntry = '0;
  endtask

  // drive one request for a cycle, starting and ending at a falling edge
  task automatic push(input int t, input logic [1:0] sz, input logic vec,
                      input logic [TAG_W-1:0] tag, input logic [ADDR_W-1:0] a,
                      input logic [DATA_W-1:0] d);
    inValid = 1; inThread = TID_W'(t); inSize = sz; inIsVector = vec;
    inTag = tag; inAddr = a; inData = d; inIsLoad = 0;
    @(negedge clk);
    idle();
  endtask

  task automatic pop(input int t);
    dequeueMask = NT'(1) << t;
    @(negedge clk);
    dequeueMask = '0;
  endtask

  initial begin
    #2_000_000;
    errors++;
    $display("FAIL watchdog: actual hung expected done");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [DATA_W-1:0] expD, vecIn;
    logic [MASK_W-1:0] expM;
    logic [ENTRY_W-1:0] e;
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    check("R1 headValid", DATA_W'(headValid), '0);
    check("R1 recycleValid", DATA_W'(recycleValid), '0);
    check("R1 fifoFull", DATA_W'(fifoFull), '0);
    check("R1 inReady", DATA_W'(inReady), DATA_W'(1));

    // R6 R11 scalar alignment table
    for (int r = 0; r < NROWS; r++) begin
      logic [31:0] d, keep;
      int off, n, t;
      d = ROWS[r][40:9]; off = int'(ROWS[r][8:3]); n = int'(ROWS[r][2:0]); t = r % NT;
      keep = (n == 1) ? 32'hFF : (n == 2) ? 32'hFFFF : 32'hFFFF_FFFF;
      expD = DATA_W'(d & keep) << (8 * off);
      expM = MASK_W'((1 << n) - 1) << off;
      push(t, ROWS[r][48:47], 1'b0, TAG_W'(r + 1), {26'h2AB_CDE0 >> 0, ROWS[r][46:41]},
           {{(LANES-1){32'hFFFF_0000}}, d});
      e = offerOf(t);
      check("R2 routing headValid", DATA_W'(headValid), DATA_W'(NT'(1) << t));
      check("R6 data", e[DATA_LSB +: DATA_W], expD);
      check("R6 mask", DATA_W'(e[MASK_W-1:0]), DATA_W'(expM));
      check("R11 addr", DATA_W'(e[ADDR_LSB +: ADDR_W]), DATA_W'({26'h2AB_CDE0, ROWS[r][46:41]}));
      check("R11 size", DATA_W'(e[SIZE_LSB +: 2]), DATA_W'(ROWS[r][48:47]));
      pop(t);
      check("R5 popped", DATA_W'(headValid), '0);
    end

    // R7 vector byte packing
    vecIn = '0; expD = '0;
    for (int i = 0; i < LANES; i++) begin
      vecIn[32*i +: 32] = {24'hABCDEF, 8'(i * 7 + 1)};
      expD[8*i +: 8] = 8'(i * 7 + 1);
    end
    push(1, 2'd0, 1'b1, 8'h40, 32'h100, vecIn);
    e = offerOf(1);
    check("R7 vector byte data", e[DATA_LSB +: DATA_W], expD);
    check("R7 vector byte mask", DATA_W'(e[MASK_W-1:0]), DATA_W'(64'h0000_0000_0000_FFFF));
    check("R11 vector flag", DATA_W'(e[VEC_BIT]), DATA_W'(1));
    pop(1);

    // R8 vector halfword and word
    vecIn = '0; expD = '0;
    for (int i = 0; i < LANES; i++) begin
      vecIn[32*i +: 32] = {16'h9999, 16'(i * 16'h0111 + 5)};
      expD[16*i +: 16] = 16'(i * 16'h0111 + 5);
    end
    push(2, 2'd1, 1'b1, 8'h41, 32'h200, vecIn);
    e = offerOf(2);
    check("R8 vector half data", e[DATA_LSB +: DATA_W], expD);
    check("R8 vector half mask", DATA_W'(e[MASK_W-1:0]), DATA_W'(64'h0000_0000_FFFF_FFFF));
    pop(2);
    push(3, 2'd2, 1'b1, 8'h42, 32'h300, vecIn);
    e = offerOf(3);
    check("R8 vector word data", e[DATA_LSB +: DATA_W], vecIn);
    check("R8 vector word mask", DATA_W'(e[MASK_W-1:0]), DATA_W'({MASK_W{1'b1}}));
    pop(3);

    // R2 neither valid nor flush: nothing written
    inThread = 2'd0; inTag = 8'h55;
    @(negedge clk);
    check("R2 no request no write", DATA_W'(headValid), '0);

    // R2 flush with valid low is written with flush bit
    inFlush = 1; inThread = 2'd2; inTag = 8'h66;
    @(negedge clk);
    idle();
    e = offerOf(2);
    check("R2 flush written", DATA_W'(headValid), DATA_W'(4'b0100));
    check("R2 flush bit", DATA_W'(e[FLUSH_BIT]), DATA_W'(1));
    check("R11 load flag", DATA_W'(e[LOAD_BIT]), '0);
    pop(2);

    // R3 rollback blocks enqueue
    rollback = 1; inValid = 1; inThread = 2'd1;
    #1 check("R3 ready low", DATA_W'(inReady), '0);
    @(negedge clk);
    idle();
    check("R3 no write", DATA_W'(headValid), '0);

    // R4 full FIFO, R5 order
    for (int k = 0; k < DEPTH; k++) push(3, 2'd2, 1'b0, TAG_W'(10 + k), 32'h0, '0);
    check("R4 full flag", DATA_W'(fifoFull), DATA_W'(4'b1000));
    inValid = 1; inThread = 2'd3; inTag = 8'h99; dequeueMask = 4'b1000;
    #1 check("R4 ready low when full", DATA_W'(inReady), '0);
    @(negedge clk);
    idle();
    for (int k = 1; k < DEPTH; k++) begin
      e = offerOf(3);
      check("R5 order", DATA_W'(e[TAG_LSB +: TAG_W]), DATA_W'(10 + k));
      pop(3);
    end
    check("R4 extra request dropped", DATA_W'(headValid), '0);

    // R5 head held without dequeue; dequeue of empty FIFO
    push(0, 2'd2, 1'b0, 8'h01, 32'h0, '0);
    push(0, 2'd2, 1'b0, 8'h02, 32'h0, '0);
    dequeueMask = 4'b0010;
    repeat (3) @(negedge clk);
    dequeueMask = '0;
    e = offerOf(0);
    check("R5 head held", DATA_W'(e[TAG_LSB +: TAG_W]), DATA_W'(8'h01));
    check("R5 empty dequeue no effect", DATA_W'(headValid), DATA_W'(4'b0001));
    pop(0);
    e = offerOf(0);
    check("R5 second entry", DATA_W'(e[TAG_LSB +: TAG_W]), DATA_W'(8'h02));

    // R9 recycle slot offered ahead of head
    missValid = 1; missThread = 2'd0; missEntry = '0; missEntry[TAG_LSB +: TAG_W] = 8'h77;
    @(negedge clk);
    idle();
    e = offerOf(0);
    check("R9 recycle valid", DATA_W'(recycleValid), DATA_W'(4'b0001));
    check("R9 recycle offered", DATA_W'(e[TAG_LSB +: TAG_W]), DATA_W'(8'h77));
    // R10 dequeue leaves recycle slot
    pop(0);
    e = offerOf(0);
    check("R10 recycle kept on pop", DATA_W'(recycleValid), DATA_W'(4'b0001));
    check("R10 fifo popped", DATA_W'(headValid), '0);
    check("R10 offer still recycled", DATA_W'(e[TAG_LSB +: TAG_W]), DATA_W'(8'h77));
    push(0, 2'd2, 1'b0, 8'h05, 32'h0, '0);
    recycleConsume = 4'b0001;
    @(negedge clk);
    idle();
    e = offerOf(0);
    check("R10 recycle cleared", DATA_W'(recycleValid), '0);
    check("R10 fifo untouched", DATA_W'(headValid), DATA_W'(4'b0001));
    check("R10 head offered", DATA_W'(e[TAG_LSB +: TAG_W]), DATA_W'(8'h05));
    // R9 load wins over simultaneous clear
    missValid = 1; missThread = 2'd1; recycleConsume = 4'b0010;
    @(negedge clk);
    idle();
    check("R9 load beats clear", DATA_W'(recycleValid), DATA_W'(4'b0010));

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule